// File: doc/BRIEF.md
# Dual-Port RAM with Run-Time Word Shape

This block is a 256-bit storage array with one write port and one read port, each driven by its own clock. A single shape input picks, at run time, how the array looks to both ports: 32 words of 8 bits, or 64 words of 4 bits. The same cells serve both shapes, so data written in one shape can be read back in the other.

Requests are sampled on each port's active clock edge, and the read result is registered. Two parameters set the active edge for each port independently, so either port can work on the rising or the falling edge of its clock. A write changes the array only when both the write enable and the block enable are high. The read output changes only on an edge where the read enable is high, and otherwise keeps its last value.

Top module: `dual_aspect_ram`

## Requirements
- R1: After reset, `rd_data` is 0 and every storage cell reads back as 0.
- R2: With `byte_mode` = 1, a write stores all 8 bits of `wr_data` at row `wr_addr[4:0]`, and a read of that row returns all 8 bits.
- R3: With `byte_mode` = 1, address bit 5 is ignored on both ports. Addresses that differ only in bit 5 select the same row.
- R4: With `byte_mode` = 0, a write stores only `wr_data[3:0]`. A read returns the addressed nibble on `rd_data[3:0]`, with `rd_data[7:4]` = 0.
- R5: With `byte_mode` = 0, `addr[5:1]` selects the row and `addr[0]` selects the half: 0 is bits 3:0 of the row and 1 is bits 7:4.
- R6: A write takes place only when `wr_en` and `blk_en` are both 1 on the active write edge. If either is 0, storage is unchanged.
- R7: On an active read edge where `rd_en` is 0, `rd_data` holds its previous value.
- R8: `rd_data` is registered. It changes only at the active read edge that samples `rd_en` = 1, and not before that edge.
- R9: Each port's active edge is rising when its polarity parameter is 1 and falling when it is 0.
- R10: When a read and a write hit the same location on the same edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_mode | input | 1 | 1 selects 32x8, 0 selects 64x4 |
| wr_en | input | 1 | Write enable |
| blk_en | input | 1 | Block enable, qualifies writes |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench writes nibbles into both halves of a row and reads the row back as a byte. A design with the half-select inverted, or with the full byte overwritten on a narrow write, returns a mixed-up value on that read.

It also writes with bit 5 of the address set while in byte mode and reads without it. A design that decodes bit 5 would miss the row.

It drives a read and a write to the same location on the same edge. A design that forwards the write data would show the new value a cycle early.

A second instance runs on falling edges. Its output is sampled between the falling edge and the next rising edge, so any polarity mix-up or combinational read path shows up.

// File: rtl/dar_pkg.sv
package dar_pkg;
    localparam int DAR_DATA_W = 8;
    localparam int DAR_ADDR_W = 6;
    localparam int DAR_NIB_W  = DAR_DATA_W / 2;
    localparam int DAR_ROW_W  = DAR_ADDR_W - 1;
    localparam int DAR_ROWS   = 1 << DAR_ROW_W;
    localparam int DAR_BITS   = DAR_ROWS * DAR_DATA_W;

    // Physical location of an access: a byte row plus a half select.
    typedef struct packed {
        logic [DAR_ROW_W-1:0] row;
        logic                 upper;
    } dar_loc_t;

    function automatic dar_loc_t dar_decode(input logic byte_mode,
                                            input logic [DAR_ADDR_W-1:0] addr);
        dar_loc_t loc;
        if (byte_mode) begin
            loc.row   = addr[DAR_ROW_W-1:0];   // top address bit unused
            loc.upper = 1'b0;
        end else begin
            loc.row   = addr[DAR_ADDR_W-1:1];
            loc.upper = addr[0];
        end
        return loc;
    endfunction
endpackage

// File: rtl/dar_clk_sel.sv
module dar_clk_sel #(
    parameter bit RISE = 1'b1
) (
    input  logic clk_in,
    output logic clk_out
);
    generate
        if (RISE) begin : g_rise
            assign clk_out = clk_in;
        end else begin : g_fall
            assign clk_out = ~clk_in;
        end
    endgenerate
endmodule

// File: rtl/dar_write_port.sv
module dar_write_port
    import dar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  logic                  wr_en,
    input  logic                  blk_en,
    input  logic [DAR_ADDR_W-1:0] wr_addr,
    input  logic [DAR_DATA_W-1:0] wr_data,
    output logic [DAR_BITS-1:0]   cells
);
    typedef struct packed {
        logic [DAR_BITS-1:0] cells;
    } wr_state_t;

    wr_state_t st_d, st_q;
    dar_loc_t  loc;
    logic      hit;

    assign loc = dar_decode(byte_mode, wr_addr);
    assign hit = wr_en & blk_en;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            if (byte_mode) begin
                st_d.cells[int'(loc.row)*DAR_DATA_W +: DAR_DATA_W] = wr_data;
            end else if (loc.upper) begin
                st_d.cells[int'(loc.row)*DAR_DATA_W + DAR_NIB_W +: DAR_NIB_W] =
                    wr_data[DAR_NIB_W-1:0];
            end else begin
                st_d.cells[int'(loc.row)*DAR_DATA_W +: DAR_NIB_W] =
                    wr_data[DAR_NIB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cells = st_q.cells;

    // R6: storage is untouched unless both enables are high
    a_r6_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && blk_en) |=> $stable(cells));

    // R4: a narrow write alters at most one nibble
    a_r4_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && blk_en && !byte_mode) |=> ($countones(cells ^ $past(cells)) <= DAR_NIB_W));
endmodule

// File: rtl/dar_read_port.sv
module dar_read_port
    import dar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  logic                  rd_en,
    input  logic [DAR_ADDR_W-1:0] rd_addr,
    input  logic [DAR_BITS-1:0]   cells,
    output logic [DAR_DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DAR_DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t             st_d, st_q;
    dar_loc_t              loc;
    logic [DAR_DATA_W-1:0] row_byte;

    assign loc      = dar_decode(byte_mode, rd_addr);
    assign row_byte = cells[int'(loc.row)*DAR_DATA_W +: DAR_DATA_W];

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (byte_mode) begin
                st_d.data = row_byte;
            end else if (loc.upper) begin
                st_d.data = {{DAR_NIB_W{1'b0}}, row_byte[DAR_DATA_W-1:DAR_NIB_W]};
            end else begin
                st_d.data = {{DAR_NIB_W{1'b0}}, row_byte[DAR_NIB_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    // R7: output holds when the read enable is low
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R4: narrow reads leave the upper half of the output clear
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !byte_mode) |=> (rd_data[DAR_DATA_W-1:DAR_NIB_W] == '0));
endmodule

// File: rtl/dual_aspect_ram.sv
module dual_aspect_ram
    import dar_pkg::*;
#(
    parameter bit WR_CLK_RISE = 1'b1,
    parameter bit RD_CLK_RISE = 1'b1
) (
    input  logic                  wr_clk,
    input  logic                  rd_clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  logic                  wr_en,
    input  logic                  blk_en,
    input  logic [DAR_ADDR_W-1:0] wr_addr,
    input  logic [DAR_DATA_W-1:0] wr_data,
    input  logic                  rd_en,
    input  logic [DAR_ADDR_W-1:0] rd_addr,
    output logic [DAR_DATA_W-1:0] rd_data
);
    logic                wclk_eff;
    logic                rclk_eff;
    logic [DAR_BITS-1:0] cells;

    dar_clk_sel #(.RISE(WR_CLK_RISE)) u_wclk (.clk_in(wr_clk), .clk_out(wclk_eff));
    dar_clk_sel #(.RISE(RD_CLK_RISE)) u_rclk (.clk_in(rd_clk), .clk_out(rclk_eff));

    dar_write_port u_wr (
        .clk       (wclk_eff),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .wr_en     (wr_en),
        .blk_en    (blk_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cells     (cells)
    );

    dar_read_port u_rd (
        .clk       (rclk_eff),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .cells     (cells),
        .rd_data   (rd_data)
    );

    // R1: output is clear while reset is applied
    always_comb begin
        if (!rst_n) a_r1_reset_clear: assert (rd_data == '0);
    end
endmodule

// File: tb/dual_aspect_ram_tb_top.sv
module dual_aspect_ram_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       byte_mode = 1'b0, wr_en = 1'b0, blk_en = 1'b0, rd_en = 1'b0;
    logic [5:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pos_rd, neg_rd;

    dual_aspect_ram #(.WR_CLK_RISE(1'b1), .RD_CLK_RISE(1'b1)) dut_i (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .wr_en(wr_en), .blk_en(blk_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pos_rd));

    dual_aspect_ram #(.WR_CLK_RISE(1'b0), .RD_CLK_RISE(1'b0)) dut_neg_i (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .wr_en(wr_en), .blk_en(blk_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(neg_rd));

    logic [7:0] ref_mem [32];
    logic [7:0] exp_rd = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic bm, input logic [5:0] a);
        logic [7:0] b;
        if (bm) return ref_mem[a[4:0]];
        b = ref_mem[a[5:1]];
        return a[0] ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
    endfunction

    task automatic model_write(input logic bm, input logic [5:0] a, input logic [7:0] d);
        if (bm) ref_mem[a[4:0]] = d;
        else if (a[0]) ref_mem[a[5:1]][7:4] = d[3:0];
        else ref_mem[a[5:1]][3:0] = d[3:0];
    endtask

    // Entered 2 ns after a rising edge; leaves 2 ns after the next one.
    task automatic cyc(input string req, input logic bm, input logic we, input logic be,
                       input logic [5:0] wa, input logic [7:0] wd,
                       input logic re, input logic [5:0] ra);
        logic [7:0] prev;
        logic [7:0] nxt;
        byte_mode = bm; wr_en = we; blk_en = be; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        prev = exp_rd;
        nxt  = re ? model_read(bm, ra) : exp_rd;   // read sees pre-write contents
        if (we && be) model_write(bm, wa, wd);
        exp_rd = nxt;
        #3;
        chk({req, " falling-edge instance R9"}, neg_rd, nxt);
        chk({req, " no change before active edge R8"}, pos_rd, prev);
        @(posedge clk); #1;
        chk(req, pos_rd, nxt);
        #1;
    endtask

    initial begin
        foreach (ref_mem[i]) ref_mem[i] = '0;
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset output", pos_rd, 8'h00);
        chk("R1 reset output falling instance", neg_rd, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 64; a += 9) cyc("R1 cleared storage", 1'b0, 1'b0, 1'b0, 6'd0, 8'd0, 1'b1, 6'(a));

        cyc("R2 byte write", 1'b1, 1'b1, 1'b1, 6'd3, 8'hA5, 1'b0, 6'd0);
        cyc("R2 byte read", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'd3);
        chk("R2 byte value", pos_rd, 8'hA5);
        cyc("R3 write with bit5 set", 1'b1, 1'b1, 1'b1, 6'h27, 8'h3C, 1'b0, 6'd0);
        cyc("R3 read without bit5", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'h07);
        chk("R3 alias value", pos_rd, 8'h3C);
        cyc("R3 read with bit5", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'h27);
        cyc("R4 nibble write", 1'b0, 1'b1, 1'b1, 6'd10, 8'hF9, 1'b0, 6'd0);
        cyc("R4 nibble read", 1'b0, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'd10);
        chk("R4 nibble value", pos_rd, 8'h09);
        cyc("R5 low half", 1'b0, 1'b1, 1'b1, 6'd20, 8'hE5, 1'b0, 6'd0);
        cyc("R5 high half", 1'b0, 1'b1, 1'b1, 6'd21, 8'hDB, 1'b0, 6'd0);
        cyc("R5 row as byte", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'd10);
        chk("R5 composed byte", pos_rd, 8'hB5);
        cyc("R6 blk_en low", 1'b1, 1'b1, 1'b0, 6'd3, 8'hFF, 1'b0, 6'd0);
        cyc("R6 wr_en low", 1'b1, 1'b0, 1'b1, 6'd3, 8'hEE, 1'b0, 6'd0);
        cyc("R6 readback", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'd3);
        chk("R6 unchanged", pos_rd, 8'hA5);
        cyc("R7 hold with new address", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b0, 6'd10);
        chk("R7 held value", pos_rd, 8'hA5);
        cyc("R10 same-edge collision", 1'b1, 1'b1, 1'b1, 6'd3, 8'h77, 1'b1, 6'd3);
        chk("R10 old contents", pos_rd, 8'hA5);
        cyc("R10 after collision", 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 6'd3);
        chk("R10 new contents", pos_rd, 8'h77);
        cyc("R10 nibble collision", 1'b0, 1'b1, 1'b1, 6'd21, 8'h02, 1'b1, 6'd21);

        for (int i = 0; i < 1500; i++) begin
            logic bm;
            logic [5:0] wa;
            logic [5:0] ra;
            bm = 1'($urandom);
            wa = ($urandom % 4 == 0) ? 6'($urandom % 8) : 6'($urandom);
            ra = ($urandom % 4 == 0) ? 6'($urandom % 8) : 6'($urandom);
            cyc(bm ? "R2 random byte mode" : "R4 random nibble mode", bm,
                ($urandom % 5) != 0, ($urandom % 5) != 0, wa, 8'($urandom),
                ($urandom % 4) != 0, ra);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule